// File: doc/BRIEF.md
# Page Translation Register File

This block keeps sixteen page numbers of twelve bits each and uses them to widen a CPU address. The top nibble of the CPU address selects one entry, and that entry's twelve bits leave the block as the page number. Downstream logic joins this page number to the untouched low address bits to form the expanded address. A mode input chooses between mapping and transparent operation. In transparent mode the address nibble is passed through unchanged, and the upper page bits are held at zero.

The data bus is eight bits wide, so software loads a register with two byte writes in a row. The first byte carries the most significant part. Its low nibble is kept in a side holding register and later becomes page bits 11..8. Each byte also writes the register's low eight bits as it arrives, so the second byte is the one that stays in bits 7..0. A register read returns only its low eight bits. Register contents are not defined after reset, so software must load every entry before it turns mapping on.

Top module: `page_map_file`

## Requirements
- R1: The block holds sixteen independent registers of twelve bits each. Register access selects an entry with `reg_idx`, where value k picks entry k.
- R2: The first accepted byte strobe after reset, or after a completed pair, is the first byte. It writes `wr_data[7:0]` into bits 7..0 of the addressed entry and `wr_data[3:0]` into bits 11..8, and it keeps `wr_data[3:0]` in the side holding register.
- R3: The second accepted byte strobe writes `wr_data[7:0]` into bits 7..0. It writes the held nibble from the first byte into bits 11..8 and leaves the held nibble unchanged. The next strobe after it is a first byte again.
- R4: Synchronous reset returns the byte pairing to the first-byte phase. Reset does not change the register contents.
- R5: A byte strobe (`wr_byte`) has no effect on any register, or on the pairing phase, while `acc_sel` is low.
- R6: With `map_en` high and `map_mode` = 1, `page` equals the twelve bits of the entry selected by `cpu_nib`. This output is combinational.
- R7: With `map_en` high and `map_mode` = 0, `page` equals {8'h00, `cpu_nib`}.
- R8: With `map_en` low, `page` is all zeros.
- R9: While `rd_en` and `acc_sel` are both high, `rd_data` shows bits 7..0 of the entry at `reg_idx`. At all other times `rd_data` is zero.
- R10: A byte accepted at a rising clock edge shows on `rd_data` and `page` straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 1 | Register access select |
| reg_idx | input | 4 | Entry chosen for register write or read |
| wr_byte | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Low byte of the selected entry, zero when not reading |
| map_en | input | 1 | Enables the page output |
| map_mode | input | 1 | 1 = mapping, 0 = transparent |
| cpu_nib | input | 4 | Top nibble of the CPU address |
| page | output | 12 | Page number |

## Verification
Every entry is loaded with a distinct pair of bytes whose high and low nibbles differ. Each entry is then translated in mapping mode, which shows whether the index decode or the nibble joining is wrong. A lone first byte, followed by a read, separates first-byte behaviour from second-byte behaviour. A pair written while `acc_sel` is low, and a reset in the middle of a pair, show whether the pairing phase is tracked correctly. Transparent mode and a low `map_en` are each tried across every nibble value, to confirm that the register contents cannot leak into `page`.

// File: rtl/page_map_pkg.sv
package page_map_pkg;
    localparam int NUM_REGS   = 16;
    localparam int PAGE_W     = 12;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int HI_W       = PAGE_W - BYTE_W;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic              en;
        idx_t              idx;
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } wr_req_t;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } byte_phase_e;

    function automatic page_t pass_nibble(input idx_t nib);
        page_t p;
        p = '0;
        p[IDX_W-1:0] = nib;
        return p;
    endfunction
endpackage

// File: rtl/byte_pairer.sv
module byte_pairer
    import page_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  idx_t              idx,
    input  logic [BYTE_W-1:0] data,
    output wr_req_t           req
);
    byte_phase_e       phase_q;
    logic [HI_W-1:0]   hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FIRST;
            hold_q  <= '0;
        end else if (strobe) begin
            if (phase_q == PH_FIRST) begin
                hold_q  <= data[HI_W-1:0];
                phase_q <= PH_SECOND;
            end else begin
                phase_q <= PH_FIRST;
            end
        end
    end

    always_comb begin
        req.en  = strobe;
        req.idx = idx;
        req.lo  = data;
        req.hi  = (phase_q == PH_FIRST) ? data[HI_W-1:0] : hold_q;
    end

    // R3
    second_keeps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && phase_q == PH_SECOND) |=> $stable(hold_q));

    // R5
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(phase_q));
endmodule

// File: rtl/page_store.sv
module page_store
    import page_map_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  idx_t    rd_idx,
    input  idx_t    xl_idx,
    output page_t   rd_entry,
    output page_t   xl_entry
);
    page_t mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (req.en && req.idx == idx_t'(g)) begin
                mem[g] <= {req.hi, req.lo};
            end
        end
    end

    assign rd_entry = mem[rd_idx];
    assign xl_entry = mem[xl_idx];

    // R2 R3 R10
    entry_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.idx == rd_idx) |=> (rd_entry == {$past(req.hi), $past(req.lo)}));
endmodule

// File: rtl/page_select.sv
module page_select
    import page_map_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  map_en,
    input  logic  map_mode,
    input  idx_t  cpu_nib,
    input  page_t entry,
    output page_t page
);
    always_comb begin
        if (!map_en)       page = '0;
        else if (map_mode) page = entry;
        else               page = pass_nibble(cpu_nib);
    end

    // R7
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (map_en && !map_mode) |-> (page[PAGE_W-1:IDX_W] == '0 && page[IDX_W-1:0] == cpu_nib));

    // R8
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !map_en |-> (page == '0));
endmodule

// File: rtl/page_map_file.sv
module page_map_file
    import page_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_sel,
    input  logic [3:0]  reg_idx,
    input  logic        wr_byte,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        map_en,
    input  logic        map_mode,
    input  logic [3:0]  cpu_nib,
    output logic [11:0] page
);
    wr_req_t req;
    page_t   rd_entry;
    page_t   xl_entry;
    logic    reading;

    byte_pairer u_pair (
        .clk    (clk),
        .rst    (rst),
        .strobe (wr_byte & acc_sel),
        .idx    (reg_idx),
        .data   (wr_data),
        .req    (req)
    );

    page_store u_store (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_idx   (reg_idx),
        .xl_idx   (cpu_nib),
        .rd_entry (rd_entry),
        .xl_entry (xl_entry)
    );

    page_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .map_en   (map_en),
        .map_mode (map_mode),
        .cpu_nib  (cpu_nib),
        .entry    (xl_entry),
        .page     (page)
    );

    assign reading = rd_en & acc_sel;
    assign rd_data = reading ? rd_entry[BYTE_W-1:0] : '0;

    // R9
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && acc_sel) |-> (rd_data == '0));

    // R6
    mapped_match_chk: assert property (@(posedge clk) disable iff (rst)
        (map_en && map_mode && !(wr_byte && acc_sel) && reg_idx == cpu_nib && rd_en && acc_sel)
            |-> (page[BYTE_W-1:0] == rd_data));
endmodule

// File: tb/page_map_file_tb_top.sv
module page_map_file_tb_top;
    logic        clk = 0;
    logic        rst;
    logic        acc_sel, wr_byte, rd_en, map_en, map_mode;
    logic [3:0]  reg_idx, cpu_nib;
    logic [7:0]  wr_data, rd_data;
    logic [11:0] page;

    int total = 0;
    int bad   = 0;
    logic [11:0] model [16];

    always #2.5 clk = ~clk;

    page_map_file dut_i (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .reg_idx(reg_idx),
        .wr_byte(wr_byte), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .map_en(map_en), .map_mode(map_mode), .cpu_nib(cpu_nib), .page(page)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [3:0] idx, input logic [7:0] d, input logic sel);
        @(negedge clk);
        acc_sel = sel; reg_idx = idx; wr_data = d; wr_byte = 1;
        @(negedge clk);
        wr_byte = 0; acc_sel = 0;
    endtask

    task automatic read_low(input logic [3:0] idx, output logic [7:0] v);
        @(negedge clk);
        acc_sel = 1; rd_en = 1; reg_idx = idx;
        #1 v = rd_data;
        @(negedge clk);
        acc_sel = 0; rd_en = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        map_en = 1; map_mode = 0;
        for (int n = 0; n < 16; n++) begin
            cpu_nib = 4'(n); #1;
            check("R7 reset transparent", page, 12'(n));
        end
        check("R9 idle bus", {4'h0, rd_data}, 12'h0);
    endtask

    task automatic t_load_all();
        logic [7:0] v;
        for (int k = 0; k < 16; k++) begin
            model[k] = {4'(15 - k), 4'(k), 4'(k ^ 4'h9)};
            put_byte(4'(k), {4'hA, model[k][11:8]}, 1);
            put_byte(4'(k), model[k][7:0], 1);
        end
        for (int k = 0; k < 16; k++) begin
            read_low(4'(k), v);
            check("R1 R3 readback", {4'h0, v}, {4'h0, model[k][7:0]});
        end
    endtask

    task automatic t_mapping();
        @(negedge clk);
        map_en = 1; map_mode = 1;
        for (int k = 0; k < 16; k++) begin
            cpu_nib = 4'(k); #1;
            check("R6 mapped page", page, model[k]);
        end
    endtask

    task automatic t_transparent_and_off();
        @(negedge clk);
        map_mode = 0;
        for (int k = 0; k < 16; k++) begin
            cpu_nib = 4'(k); #1;
            check("R7 transparent", page, 12'(k));
        end
        map_en = 0;
        for (int k = 0; k < 16; k++) begin
            map_mode = k[0]; cpu_nib = 4'(k); #1;
            check("R8 disabled", page, 12'h000);
        end
        map_en = 1; map_mode = 1;
    endtask

    task automatic t_first_byte_only();
        logic [7:0] v;
        put_byte(4'd3, 8'h5C, 1);
        read_low(4'd3, v);
        check("R2 R10 first byte low", {4'h0, v}, 12'h05C);
        @(negedge clk); cpu_nib = 4'd3; #1;
        check("R2 first byte high", page, 12'hC5C);
        put_byte(4'd3, 8'h21, 1);
        model[3] = 12'hC21;
        #1 check("R3 pair done", page, 12'hC21);
        put_byte(4'd4, 8'h07, 1);
        model[4] = 12'h707;
        cpu_nib = 4'd4; #1;
        check("R3 phase restarts", page, 12'h707);
        put_byte(4'd4, 8'hE4, 1);
        model[4] = 12'h7E4;
        #1 check("R3 second of pair", page, 12'h7E4);
    endtask

    task automatic t_unselected();
        logic [7:0] v;
        put_byte(4'd6, 8'hFF, 0);
        put_byte(4'd6, 8'h00, 0);
        read_low(4'd6, v);
        check("R5 ignored write", {4'h0, v}, {4'h0, model[6][7:0]});
        @(negedge clk); cpu_nib = 4'd6; #1;
        check("R5 ignored page", page, model[6]);
        put_byte(4'd7, 8'h02, 1);
        put_byte(4'd7, 8'h9B, 1);
        model[7] = 12'h29B;
        cpu_nib = 4'd7; #1;
        check("R5 phase untouched", page, 12'h29B);
    endtask

    task automatic t_reset_mid_pair();
        put_byte(4'd8, 8'h0D, 1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        cpu_nib = 4'd8; #1;
        check("R4 contents kept", page, 12'hD0D);
        put_byte(4'd8, 8'h03, 1);
        #1 check("R4 first after reset", page, 12'h303);
        put_byte(4'd8, 8'h77, 1);
        #1 check("R4 pair after reset", page, 12'h377);
    endtask

    initial begin
        rst = 1; acc_sel = 0; wr_byte = 0; rd_en = 0; wr_data = 0;
        reg_idx = 0; map_en = 0; map_mode = 0; cpu_nib = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_load_all();
        t_mapping();
        t_transparent_and_off();
        t_first_byte_only();
        t_unselected();
        t_reset_mid_pair();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule